// File: doc/BRIEF.md
# Self-Timed Byte Store Controller

This block gives a CPU byte-wide access to a separate nonvolatile data space of 512 locations. The CPU reaches it through three registers on its I/O register bus: an address register, a data register and a control register. A read or write is started by writing a strobe bit into the control register. The block then holds the CPU with a stall output for a fixed number of cycles, and the count differs for reads and writes.

A write needs an unlock first. Software sets an arm bit, which stays set for a short window and then clears itself. A write strobe is taken only while that bit is set. An accepted write then runs on its own for a parameterised number of cycles. A busy bit in the control register shows this interval, and software polls it before it starts the next access. While busy is high, new read and write strobes are dropped.

The storage is held in internal registers. At reset every location is set to all ones, which stands for the erased state.

Top module: `nvmem_ctrl`

## Requirements
- R1: After reset every location reads 0xFF. The address, data and control registers read zero, and `cpu_stall` is low.
- R2: A read strobe (control bit 0) makes `cpu_stall` high for exactly 4 cycles, starting the cycle after the strobe. When the stall ends, the data register holds the addressed byte.
- R3: An accepted write strobe (control bit 1) makes `cpu_stall` high for exactly 2 cycles, starting the cycle after the strobe.
- R4: After an accepted write strobe, busy (control bit 3) reads 1 for exactly WR_LAT cycles. Once busy has dropped, the addressed location holds the byte that was in the data register when the strobe came.
- R5: Writing control bit 2 sets the arm bit. The arm bit reads 1 for 4 cycles and then clears itself. A write strobe is taken only if arm was already set before that bus write: arm followed by a strobe up to 4 bus cycles later is taken. A strobe 5 cycles later, or one sent in the same write as the arm bit, is dropped. A dropped strobe causes no stall and no busy, and leaves the storage unchanged.
- R6: Read or write strobes sent while busy is 1 are ignored. There is no stall, the data register is unchanged, and the storage is unchanged.
- R7: Only nine address bits are kept: all 8 bits of the low address register and bit 0 of the high address register. Bits 7:1 of the high register are discarded and read back as 0.
- R8: Register select codes are 0 for the low address byte, 1 for the high address byte, 2 for data and 3 for control. Strobe bits 0 and 1 always read back as 0.
- R9: If one control write sets both strobes while arm is set, only the write is performed, with a 2-cycle stall and busy set.
- R10: Control register writes that arrive while `cpu_stall` is high are ignored. They neither extend the stall nor set the arm bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 2 | Register select for bus access |
| io_we | input | 1 | Bus write enable, sampled at the clock edge |
| io_wdata | input | 8 | Bus write data |
| io_rdata | output | 8 | Read data of the selected register, combinational |
| cpu_stall | output | 1 | Holds the CPU while an access completes |

## Verification
The hardest states to reach are the ones that need two events with an exact gap between them. These are the last cycle of the arm window, a strobe placed inside the busy interval after its stall has ended, and a control write placed inside a read stall. The bench uses a bus task that uses one clock edge per call and adds fixed idle gaps, so each strobe lands on a known edge relative to the arm, stall or busy interval. The result is then checked through the stall output, the busy and arm bits, and later reads of the affected locations.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_DATA    = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

    localparam int CB_RD   = 0;
    localparam int CB_WR   = 1;
    localparam int CB_ARM  = 2;
    localparam int CB_BUSY = 3;

    typedef struct packed {
        logic rd_go;
        logic wr_go;
        logic arm_set;
    } ctl_req_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic ctl_req_t decode_ctl(input logic [7:0] v);
        ctl_req_t r;
        r.rd_go   = v[CB_RD];
        r.wr_go   = v[CB_WR];
        r.arm_set = v[CB_ARM];
        return r;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvm_guard.sv
module nvm_guard #(
    parameter int ARM_CYC = 4,
    localparam int CW     = $clog2(ARM_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_set,
    input  logic consume,
    output logic arm
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (consume)    cnt_q <= '0;
        else if (arm_set)    cnt_q <= CW'(ARM_CYC);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign arm = (cnt_q != 0);

    // R5
    arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(arm) && !consume) |=> arm);
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int DEPTH    = 512,
    parameter int DW       = 8,
    parameter int RD_STALL = 4,
    parameter int WR_STALL = 2,
    parameter int WR_LAT   = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int SW      = $clog2(max2(RD_STALL, WR_STALL) + 1),
    localparam int BW      = $clog2(WR_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_valid,
    input  ctl_req_t      req,
    input  logic          arm,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          stall,
    output logic          busy,
    output logic          arm_set,
    output logic          wr_fire,
    output logic          rd_fire,
    output logic          rd_done,
    output logic [AW-1:0] rd_addr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata
);
    logic [SW-1:0] stall_q;
    logic [BW-1:0] busy_q;
    op_e           op_q;
    logic          accept;

    assign stall   = (stall_q != 0);
    assign busy    = (busy_q != 0);
    assign accept  = ctl_valid && !stall && !busy;
    assign wr_fire = accept && req.wr_go && arm;
    assign rd_fire = accept && req.rd_go && !wr_fire;
    assign arm_set = ctl_valid && !stall && req.arm_set;
    assign rd_done = (op_q == OP_READ) && (stall_q == SW'(1));
    assign mem_we  = (busy_q == BW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q   <= '0;
            busy_q    <= '0;
            op_q      <= OP_IDLE;
            rd_addr   <= '0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            if (wr_fire) begin
                stall_q   <= SW'(WR_STALL);
                busy_q    <= BW'(WR_LAT);
                op_q      <= OP_WRITE;
                mem_waddr <= addr;
                mem_wdata <= wdata;
            end else begin
                if (rd_fire) begin
                    stall_q <= SW'(RD_STALL);
                    op_q    <= OP_READ;
                    rd_addr <= addr;
                end else if (stall_q != 0) begin
                    stall_q <= stall_q - 1'b1;
                    if (stall_q == SW'(1)) op_q <= OP_IDLE;
                end
                if (busy_q != 0) busy_q <= busy_q - 1'b1;
            end
        end
    end

    // R2
    rd_start_chk: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> (stall && !busy));
    // R3
    wr_start_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> (stall && busy));
    // R10
    stall_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && !busy) |=> !$rose(busy));
endmodule

// File: rtl/nvm_regs.sv
module nvm_regs
    import nvm_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int HI_W = AW - DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    io_sel,
    input  logic          io_we,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    input  logic          busy,
    input  logic          arm,
    input  logic          rd_done,
    input  logic [DW-1:0] rd_byte,
    output logic          ctl_valid,
    output ctl_req_t      req,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    reg_sel_e sel;
    assign sel       = reg_sel_e'(io_sel);
    assign ctl_valid = io_we && (sel == SEL_CTRL);
    assign req       = decode_ctl(io_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            data <= '0;
        end else begin
            if (io_we && sel == SEL_ADDR_LO) addr[DW-1:0] <= io_wdata;
            if (io_we && sel == SEL_ADDR_HI) addr[AW-1:DW] <= io_wdata[HI_W-1:0];
            if (rd_done)                     data <= rd_byte;
            else if (io_we && sel == SEL_DATA) data <= io_wdata;
        end
    end

    always_comb begin
        io_rdata = '0;
        unique case (sel)
            SEL_ADDR_LO: io_rdata = addr[DW-1:0];
            SEL_ADDR_HI: io_rdata[HI_W-1:0] = addr[AW-1:DW];
            SEL_DATA:    io_rdata = data;
            SEL_CTRL: begin
                io_rdata[CB_ARM]  = arm;
                io_rdata[CB_BUSY] = busy;
            end
        endcase
    end
endmodule

// File: rtl/nvmem_ctrl.sv
module nvmem_ctrl
    import nvm_pkg::*;
#(
    parameter int DEPTH    = 512,
    parameter int DW       = 8,
    parameter int RD_STALL = 4,
    parameter int WR_STALL = 2,
    parameter int ARM_CYC  = 4,
    parameter int WR_LAT   = 8,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    io_sel,
    input  logic          io_we,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          cpu_stall
);
    ctl_req_t      req;
    logic          ctl_valid, busy, arm, arm_set, wr_fire, rd_fire, rd_done, mem_we;
    logic [AW-1:0] addr, rd_addr, mem_waddr;
    logic [DW-1:0] data, mem_wdata, rd_byte;

    nvm_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .io_sel(io_sel), .io_we(io_we), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .busy(busy), .arm(arm), .rd_done(rd_done),
        .rd_byte(rd_byte), .ctl_valid(ctl_valid), .req(req), .addr(addr), .data(data)
    );

    nvm_guard #(.ARM_CYC(ARM_CYC)) u_guard (
        .clk(clk), .rst(rst), .arm_set(arm_set), .consume(wr_fire), .arm(arm)
    );

    nvm_seq #(.DEPTH(DEPTH), .DW(DW), .RD_STALL(RD_STALL), .WR_STALL(WR_STALL),
              .WR_LAT(WR_LAT)) u_seq (
        .clk(clk), .rst(rst), .ctl_valid(ctl_valid), .req(req), .arm(arm),
        .addr(addr), .wdata(data), .stall(cpu_stall), .busy(busy),
        .arm_set(arm_set), .wr_fire(wr_fire), .rd_fire(rd_fire), .rd_done(rd_done),
        .rd_addr(rd_addr), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    nvm_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_byte)
    );

    // R5
    wr_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(arm));
    // R5
    arm_consumed_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> !arm);
    // R4
    wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mem_we));
    // R2
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !cpu_stall);
    // R6
    busy_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd_fire);
endmodule

// File: tb/nvmem_ctrl_bench.sv
module nvmem_ctrl_bench;
    localparam int WR_LAT = 8;
    localparam int DEPTH  = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] io_sel = 2'd0;
    logic       io_we = 1'b0;
    logic [7:0] io_wdata = 8'd0;
    logic [7:0] io_rdata;
    logic       cpu_stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nvmem_ctrl #(.WR_LAT(WR_LAT)) u_nvmem_ctrl (
        .clk(clk), .rst(rst), .io_sel(io_sel), .io_we(io_we),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_stall(cpu_stall)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 91) & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        io_sel = s; io_wdata = d; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] d);
        io_sel = s;
        #1;
        d = io_rdata;
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (cpu_stall && n < 50) begin n++; @(negedge clk); end
    endtask

    task automatic count_busy(output int n);
        logic [7:0] v;
        n = 0;
        peek(2'd3, v);
        while (v[3] && n < 200) begin n++; @(negedge clk); peek(2'd3, v); end
    endtask

    task automatic set_addr(input int a);
        bus_wr(2'd0, 8'(a));
        bus_wr(2'd1, {7'h55, 1'(a >> 8)});
    endtask

    task automatic do_read(input int a, output logic [7:0] d, output int ns);
        set_addr(a);
        bus_wr(2'd3, 8'h01);
        count_stall(ns);
        peek(2'd2, d);
    endtask

    task automatic do_write(input int a, input logic [7:0] d, output int ns, output int nb);
        set_addr(a);
        bus_wr(2'd2, d);
        bus_wr(2'd3, 8'h04);
        bus_wr(2'd3, 8'h02);
        count_stall(ns);
        count_busy(nb);
        nb += ns;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int ns, nb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 R8: reset state of registers and stall
        for (int s = 0; s < 4; s++) begin
            peek(2'(s), v);
            check(v == 8'h00, "R1 reg reset", v, 0);
        end
        check(cpu_stall == 1'b0, "R1 stall reset", cpu_stall, 0);

        // R1 R2: every location erased, read stall of 4
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a, v, ns);
            check(v == 8'hFF, "R1 erased", v, 8'hFF);
            check(ns == 4, "R2 read stall", ns, 4);
        end

        // R3 R4 R7: write sweep
        for (int a = 0; a < DEPTH; a++) begin
            do_write(a, pat(a), ns, nb);
            check(ns == 2, "R3 write stall", ns, 2);
            check(nb == WR_LAT, "R4 busy length", nb, WR_LAT);
            if (a % 64 == 0) begin
                peek(2'd1, v);
                check(v == 8'(a >> 8), "R7 high addr readback", v, a >> 8);
                peek(2'd3, v);
                check(v[1:0] == 2'b00, "R8 strobes read zero", v, 0);
            end
        end

        // R2 R4 R7: read back sweep
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a, v, ns);
            check(v == pat(a), "R4 stored byte", v, pat(a));
            check(ns == 4, "R2 read stall", ns, 4);
        end

        // R5: arm window expiry
        bus_wr(2'd3, 8'h04);
        peek(2'd3, v); check(v[2] == 1'b1, "R5 arm set", v, 8'h04);
        repeat (3) @(negedge clk);
        peek(2'd3, v); check(v[2] == 1'b1, "R5 arm last cycle", v, 8'h04);
        @(negedge clk);
        peek(2'd3, v); check(v[2] == 1'b0, "R5 arm cleared", v, 0);
        set_addr(20);
        bus_wr(2'd2, 8'h3C);
        bus_wr(2'd3, 8'h02);
        check(cpu_stall == 1'b0, "R5 late strobe no stall", cpu_stall, 0);
        peek(2'd3, v); check(v[3] == 1'b0, "R5 late strobe no busy", v, 0);
        do_read(20, v, ns);
        check(v == pat(20), "R5 late strobe no store", v, pat(20));

        // R5: strobe on final arm cycle is taken
        bus_wr(2'd2, 8'hA5);
        bus_wr(2'd3, 8'h04);
        repeat (3) @(negedge clk);
        bus_wr(2'd3, 8'h02);
        count_stall(ns);
        check(ns == 2, "R5 edge strobe taken", ns, 2);
        count_busy(nb);
        do_read(20, v, ns);
        check(v == 8'hA5, "R5 edge strobe stored", v, 8'hA5);

        // R5: arm and strobe in same write is dropped
        set_addr(21);
        bus_wr(2'd2, 8'h11);
        bus_wr(2'd3, 8'h06);
        check(cpu_stall == 1'b0, "R5 same-write no stall", cpu_stall, 0);
        repeat (5) @(negedge clk);
        do_read(21, v, ns);
        check(v == pat(21), "R5 same-write no store", v, pat(21));

        // R6: strobes during busy ignored
        set_addr(10);
        bus_wr(2'd2, 8'h5A);
        bus_wr(2'd3, 8'h04);
        bus_wr(2'd3, 8'h02);
        count_stall(ns);
        bus_wr(2'd3, 8'h01);
        check(cpu_stall == 1'b0, "R6 read during busy no stall", cpu_stall, 0);
        peek(2'd2, v); check(v == 8'h5A, "R6 data reg kept", v, 8'h5A);
        bus_wr(2'd0, 8'd11);
        bus_wr(2'd2, 8'hC3);
        bus_wr(2'd3, 8'h04);
        bus_wr(2'd3, 8'h02);
        check(cpu_stall == 1'b0, "R6 write during busy no stall", cpu_stall, 0);
        count_busy(nb);
        repeat (6) @(negedge clk);
        do_read(11, v, ns);
        check(v == pat(11), "R6 busy write dropped", v, pat(11));
        do_read(10, v, ns);
        check(v == 8'h5A, "R6 first write kept", v, 8'h5A);

        // R9: both strobes with arm set performs write
        set_addr(30);
        bus_wr(2'd2, 8'h77);
        bus_wr(2'd3, 8'h04);
        bus_wr(2'd3, 8'h03);
        count_stall(ns);
        check(ns == 2, "R9 write wins stall", ns, 2);
        count_busy(nb);
        check(nb == WR_LAT - 2, "R9 write wins busy", nb, WR_LAT - 2);
        do_read(30, v, ns);
        check(v == 8'h77, "R9 byte stored", v, 8'h77);

        // R10: control writes during read stall ignored
        set_addr(40);
        bus_wr(2'd3, 8'h01);
        bus_wr(2'd3, 8'h05);
        count_stall(ns);
        check(ns + 1 == 4, "R10 stall not extended", ns + 1, 4);
        peek(2'd3, v); check(v[2] == 1'b0, "R10 arm not set", v, 0);
        peek(2'd2, v); check(v == pat(40), "R10 read result", v, pat(40));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule